// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the integer execute stage of a 32-bit load/store core. Each cycle it takes two source operands, a 16-bit immediate field, a 4-bit operation code and a one-bit immediate-select. It returns a 32-bit result with a write strobe for the register file, and it keeps a registered status word that holds zero, sign, overflow and carry bits. The operations are moves, adds, bitwise logic and shifts. Register storage and decode sit outside the block. Source `a` is the first operand. Source `b` is the second operand, or the value that is moved, inverted or shifted.

The flags change according to the class of the operation. Arithmetic adds rewrite all four flags. Bitwise operations rewrite zero and sign, clear overflow and keep carry. Moves, address moves and shifts leave the status word unchanged. The immediate is sign-extended or zero-extended as the operation requires, and the high-half move places it in the upper half of the word before adding it.

Top module: `exu_alu_flags`

## Requirements
- R1: While `rst_n` is low, `res`, `res_we` and `status` are all zero.
- R2: An operation presented at a rising clock edge updates `res`, `res_we` and `status` at that same edge, so the effect is visible one cycle after the stimulus. For codes 0 to 11, `res_we` is 1 during the following cycle.
- R3: The move codes work as follows. Code 0 (MOV) gives `b`, or the sign-extended `imm[4:0]` when `imm_sel`=1. Code 3 (MOVEA) gives `a` + sign-extended `imm[15:0]`. Code 4 (MOVHI) gives `a` + (`imm` << 16). None of the three changes `status`.
- R4: Code 1 (ADD) gives `a` + `b`, or `a` + sign-extended `imm[4:0]` when `imm_sel`=1. Code 2 (ADDW) gives `a` + sign-extended `imm[15:0]`.
- R5: After code 1 or 2, the flags are set as follows. Z is 1 when the result is zero. S is result bit 31. CY is 1 when the unsigned result is below either addend. OV is 1 when both addends have the same bit 31 and the result's bit 31 differs from it.
- R6: The bitwise codes work as follows. Code 5 (OR), code 6 (AND) and code 7 (XOR) combine `a` with `b`, or with the zero-extended `imm[15:0]` when `imm_sel`=1. Code 8 (NOT) gives ~`b` and ignores `imm_sel`.
- R7: Codes 5 to 8 set Z from the result and S from result bit 31. They clear OV and keep CY. For code 6 with `imm_sel`=1, S is 0.
- R8: The shift codes shift `b` as follows. Code 9 (SHL) shifts left with zero fill. Code 10 (SHR) shifts right with zero fill. Code 11 (SAR) shifts right and copies bit 31 into the vacated bits. The amount is `a[4:0]`, or the zero-extended `imm[4:0]` when `imm_sel`=1. Higher bits of the amount source are ignored.
- R9: Shift codes 9 to 11 leave `status` unchanged.
- R10: Codes 12 to 15 do nothing. `res_we` is 0 in the next cycle, and both `res` and `status` hold their values.
- R11: In `status`, Z is bit 0, S is bit 1, OV is bit 2 and CY is bit 3. Bits 31:4 stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| imm_sel | input | 1 | Selects the immediate form instead of the register form |
| a | input | 32 | First source operand |
| b | input | 32 | Second source operand, or the moved, inverted or shifted value |
| imm | input | 16 | Immediate field |
| res | output | 32 | Registered result |
| res_we | output | 1 | Result write strobe, valid for one cycle |
| status | output | 32 | Registered status word |

## Verification
Every output of this block changes at the clock edge that samples the operation, so the result, the write strobe and every flag are due exactly one cycle after the stimulus. The bench drives inputs at the falling edge and samples the outputs 1 ns after the next rising edge. It compares them with a reference model that carries its own copy of the status word from one operation to the next. That carried copy is how the bench checks that CY survives bitwise operations and that moves, shifts and unused codes leave both the status word and the held result untouched.

// File: rtl/exu_alu_flags.sv
module exu_alu_flags #(
  parameter int W     = 32,
  parameter int IMM_S = 5,
  parameter int IMM_L = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic             imm_sel,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [IMM_L-1:0] imm,
  output logic [W-1:0]     res,
  output logic             res_we,
  output logic [W-1:0]     status
);
  localparam int SHW = $clog2(W);
  localparam int FZ = 0, FS = 1, FOV = 2, FCY = 3;

  typedef enum logic [3:0] {
    MOV, ADD, ADDW, MOVEA, MOVHI, ORX, ANDX, XORX, NOTX, SHL, SHR, SAR
  } op_e;
  typedef enum logic [1:0] {KEEP, ARITH, LOGIC} fcls_e;

  logic [W-1:0] sx_s, sx_l, zx_l, hi_l, addend, lrhs, nres;
  logic [W:0]   sum;
  logic [SHW-1:0] shamt;
  logic         nwe;
  fcls_e        fcls;

  assign sx_s   = {{(W-IMM_S){imm[IMM_S-1]}}, imm[IMM_S-1:0]};
  assign sx_l   = {{(W-IMM_L){imm[IMM_L-1]}}, imm};
  assign zx_l   = {{(W-IMM_L){1'b0}}, imm};
  assign hi_l   = {imm, {(W-IMM_L){1'b0}}};
  assign addend = (op == ADDW || op == MOVEA) ? sx_l :
                  (op == MOVHI) ? hi_l : (imm_sel ? sx_s : b);
  assign sum    = {1'b0, a} + {1'b0, addend};
  assign lrhs   = imm_sel ? zx_l : b;
  assign shamt  = imm_sel ? imm[SHW-1:0] : a[SHW-1:0];

  always_comb begin
    nres = res;
    nwe  = 1'b1;
    fcls = KEEP;
    case (op)
      MOV:   nres = imm_sel ? sx_s : b;
      ADD, ADDW: begin
        nres = sum[W-1:0];
        fcls = ARITH;
      end
      MOVEA, MOVHI: nres = sum[W-1:0];
      ORX:  begin nres = a | lrhs; fcls = LOGIC; end
      ANDX: begin nres = a & lrhs; fcls = LOGIC; end
      XORX: begin nres = a ^ lrhs; fcls = LOGIC; end
      NOTX: begin nres = ~b;       fcls = LOGIC; end
      SHL:  nres = b << shamt;
      SHR:  nres = b >> shamt;
      SAR:  nres = W'($signed(b) >>> shamt);
      default: nwe = 1'b0;
    endcase
  end

  logic [W-1:0] nstat;
  always_comb begin
    nstat = status;
    if (fcls != KEEP) begin
      nstat[FZ]  = (nres == '0);
      nstat[FS]  = nres[W-1] & ~(op == ANDX && imm_sel);
      nstat[FOV] = 1'b0;
    end
    if (fcls == ARITH) begin
      nstat[FCY] = sum[W];
      nstat[FOV] = (a[W-1] == addend[W-1]) && (nres[W-1] != a[W-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res    <= '0;
      res_we <= 1'b0;
      status <= '0;
    end else begin
      res    <= nres;
      res_we <= nwe;
      status <= nstat;
    end
  end
endmodule

module exu_alu_flags_chk #(
  parameter int W     = 32,
  parameter int IMM_L = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op,
  input logic [W-1:0]     a,
  input logic [IMM_L-1:0] imm,
  input logic [W-1:0]     res,
  input logic             res_we,
  input logic [W-1:0]     status
);
  // R10
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd12) |=> (!res_we && $stable(status) && $stable(res)));
  // R2
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op < 4'd12) |=> res_we);
  // R9
  shift_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd9 && op <= 4'd11) |=> $stable(status));
  // R3
  move_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 || op == 4'd3 || op == 4'd4) |=> $stable(status));
  // R3
  movhi_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd4) |=> (res == $past(a) + {$past(imm), {(W-IMM_L){1'b0}}}));
  // R5
  add_zs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd1 || op == 4'd2) |=> (status[0] == (res == '0) && status[1] == res[W-1]));
  // R7
  logic_ov_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd5 && op <= 4'd8) |=> (!status[2] && status[3] == $past(status[3])));
endmodule

bind exu_alu_flags exu_alu_flags_chk #(.W(W), .IMM_L(IMM_L)) u_chk (.*);

// File: tb/sim_exu_alu_flags.sv
`timescale 1ns/1ps
module sim_exu_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd15;
  logic        imm_sel = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic [31:0] res, status;
  logic        res_we;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_stat = '0, m_res = '0;

  always #5 clk = ~clk;

  exu_alu_flags u0 (.clk, .rst_n, .op, .imm_sel, .a, .b, .imm, .res, .res_we, .status);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, op, act, exp);
    end
  endtask

  function automatic logic [31:0] f_res(input logic [3:0] o, input logic [31:0] x, y,
                                        input logic [15:0] im, input logic is, input logic [31:0] prev);
    logic [31:0] s5, s16, z16, src;
    logic [4:0]  n;
    s5  = {{27{im[4]}}, im[4:0]};
    s16 = {{16{im[15]}}, im};
    z16 = {16'h0, im};
    src = is ? z16 : y;
    n   = is ? im[4:0] : x[4:0];
    case (o)
      0: return is ? s5 : y;
      1: return x + (is ? s5 : y);
      2, 3: return x + s16;
      4: return x + {im, 16'h0};
      5: return x | src;
      6: return x & src;
      7: return x ^ src;
      8: return ~y;
      9: return y << n;
      10: return y >> n;
      11: return 32'($signed(y) >>> n);
      default: return prev;
    endcase
  endfunction

  function automatic logic [31:0] f_stat(input logic [3:0] o, input logic [31:0] x, y,
                                         input logic [15:0] im, input logic is,
                                         input logic [31:0] old, input logic [31:0] r);
    logic [31:0] st, ad;
    st = old;
    if (o == 1 || o == 2) begin
      ad = (o == 2) ? {{16{im[15]}}, im} : (is ? {{27{im[4]}}, im[4:0]} : y);
      st[0] = (r == 0);
      st[1] = r[31];
      st[3] = (r < x) || (r < ad);
      st[2] = (x[31] == ad[31]) && (r[31] != x[31]);
    end else if (o >= 5 && o <= 8) begin
      st[0] = (r == 0);
      st[1] = (o == 6 && is) ? 1'b0 : r[31];
      st[2] = 1'b0;
    end
    return st;
  endfunction

  function automatic string res_tag(input logic [3:0] o);
    if (o == 0 || o == 3 || o == 4) return "R3";
    if (o == 1 || o == 2) return "R4";
    if (o >= 5 && o <= 8) return "R6";
    if (o >= 9 && o <= 11) return "R8";
    return "R10";
  endfunction

  function automatic string stat_tag(input logic [3:0] o);
    if (o == 1 || o == 2) return "R5";
    if (o >= 5 && o <= 8) return "R7";
    if (o >= 9 && o <= 11) return "R9";
    if (o <= 4) return "R3";
    return "R10";
  endfunction

  task automatic run(input logic [3:0] o, input logic [31:0] x, y, input logic [15:0] im, input logic is);
    logic [31:0] er, es;
    @(negedge clk);
    op = o; a = x; b = y; imm = im; imm_sel = is;
    er = f_res(o, x, y, im, is, m_res);
    es = f_stat(o, x, y, im, is, m_stat, er);
    @(posedge clk);
    #1;
    check(res == er, res_tag(o), res, er);
    check(status == es, stat_tag(o), status, es);
    check(res_we == (o < 12), "R2", {31'h0, res_we}, {31'h0, (o < 12)});
    check(status[31:4] == 0, "R11", status, es);
    m_res = er;
    m_stat = es;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(res == 0, "R1", res, 0);
    check(res_we == 0, "R1", {31'h0, res_we}, 0);
    check(status == 0, "R1", status, 0);
    @(negedge clk) rst_n = 1'b1;

    run(1, 32'h7fffffff, 32'h00000001, 16'h0, 0);   // R5 overflow
    run(1, 32'hffffffff, 32'h00000001, 16'h0, 0);   // R5 carry + zero
    run(5, 32'h00000000, 32'h00000000, 16'h0000, 1); // R7 CY kept
    run(1, 32'h00000005, 32'h0, 16'h001f, 1);       // R4 sext imm5 = -1
    run(2, 32'h00000000, 32'h0, 16'h8000, 0);       // R4 sext imm16
    run(2, 32'h80000000, 32'h0, 16'h8000, 0);       // R5 neg overflow
    run(0, 32'h0, 32'h0, 16'h0010, 1);              // R3 mov imm5
    run(3, 32'h00001000, 32'h0, 16'hfff0, 0);       // R3 movea
    run(4, 32'h00001234, 32'h0, 16'hbeef, 0);       // R3 movhi
    run(5, 32'h80000000, 32'h0, 16'h8001, 1);       // R6 ori zext
    run(6, 32'hffffffff, 32'h0, 16'h8000, 1);       // R7 andi S clear
    run(6, 32'h80000000, 32'h80000000, 16'h0, 0);   // R7 and S set
    run(7, 32'h12345678, 32'h12345678, 16'h0, 0);   // R7 xor zero
    run(8, 32'h0, 32'h00000000, 16'hffff, 1);       // R6 not
    run(9, 32'hffffffe4, 32'h00000003, 16'h0, 0);   // R8 shl amount 4
    run(10, 32'h0, 32'h80000000, 16'hffff, 1);      // R8 shr imm 31
    run(11, 32'h0, 32'h80000000, 16'h0024, 1);      // R8 sar imm 4
    run(11, 32'h0000003f, 32'h7fff0000, 16'h0, 0);  // R8 sar positive
    run(12, 32'h1, 32'h2, 16'h3, 0);                // R10
    run(15, 32'hffffffff, 32'hffffffff, 16'hffff, 1); // R10

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      case ($urandom() % 6)
        0: x = 32'h7fffffff;
        1: y = 32'hffffffff;
        2: x = 32'h80000000;
        default: ;
      endcase
      run(4'($urandom() % 16), x, y, 16'($urandom()), 1'($urandom()));
    end
    finish_up();
  end
endmodule